// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs division one quotient bit at a time using a non-restoring recurrence. Three flags carry the state between steps: a quotient-sign flag Q, a divisor-sign flag M and a result flag T. In each step the partial remainder moves left by one place, with T entering at the bottom. The divisor is then added to it or subtracted from it, and the outcome of that add or subtract sets the new Q and T. The block has two parts. A registered single-step port applies one step per strobe, so a controller can drive its own loop. A built-in sequencer runs a whole division once it is started.

The sequencer takes an initial remainder, which is the high word of the dividend, and a quotient register, which holds the low word at the start. It then runs one step per clock for the full word width. On each step the top bit of the quotient register supplies the incoming T, and the new T is rotated into the bottom of that register. For unsigned operands whose high word is smaller than the divisor, starting with Q, M and T all at 0 leaves the exact quotient in that register. The caller prepares the initial flags and applies any signed correction afterwards.

Top module: `ndiv_unit`

## Requirements
- R1: A step shifts the remainder left by one position and places the incoming T at bit 0.
- R2: The operation depends on the incoming Q and M. When they are equal the step subtracts the divisor from the shifted remainder; when they differ it adds the divisor.
- R3: The new Q equals bit W-1 of the remainder before the shift, XOR the carry out of the add (or the borrow of the subtract), XOR M.
- R4: The new T is 1 exactly when the new Q equals M, and 0 otherwise.
- R5: The single-step outputs are registered. They take the step result on the clock edge that samples `stp_en` high, `stp_vld` is high for the cycle after each such edge, and the outputs hold their values while `stp_en` is low.
- R6: M is never changed by a step. `sq_m_o` keeps the value loaded at start for the whole run and afterwards.
- R7: A `sq_start` sampled while idle loads the operands and raises `sq_busy`. The sequencer then performs exactly W steps, one per clock. Each step takes its incoming T from bit W-1 of the quotient register, and the register then rotates left with the new T entering at bit 0.
- R8: On the edge of the final step, `sq_busy` falls and `sq_done` rises. `sq_done` is high for exactly one cycle.
- R9: A `sq_start` sampled while busy is ignored. Neither the operands nor the run timing change.
- R10: Reset makes the sequencer idle and clears its step counter, `sq_done` and all single-step outputs. A reset in the middle of a run aborts it.
- R11: Start with Q, M and T at 0, `sq_rem` holding the high word and `sq_quo` holding the low word, and with the high word smaller than the divisor. After W steps `sq_quo_o` is the unsigned quotient of the 2W-bit dividend divided by the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stp_en | input | 1 | Single-step strobe |
| stp_divisor | input | W | Divisor for the single step |
| stp_rem | input | W | Partial remainder before the step |
| stp_q | input | 1 | Incoming Q flag |
| stp_m | input | 1 | M flag |
| stp_t | input | 1 | Incoming T flag |
| stp_rem_o | output | W | Remainder after the step |
| stp_q_o | output | 1 | Q after the step |
| stp_t_o | output | 1 | T after the step |
| stp_vld | output | 1 | Single-step result updated this cycle |
| sq_start | input | 1 | Start a full division |
| sq_divisor | input | W | Sequencer divisor |
| sq_rem | input | W | Initial remainder (high dividend word) |
| sq_quo | input | W | Initial quotient register (low dividend word) |
| sq_q | input | 1 | Initial Q flag |
| sq_m | input | 1 | M flag for the run |
| sq_busy | output | 1 | Sequencer running |
| sq_done | output | 1 | One-cycle completion pulse |
| sq_rem_o | output | W | Current remainder register |
| sq_quo_o | output | W | Current quotient register |
| sq_q_o | output | 1 | Current Q flag |
| sq_m_o | output | 1 | Held M flag |
| sq_t_o | output | 1 | Current T flag |

## Verification
A single-step result appears one clock edge after the edge that samples `stp_en`. The bench therefore drives each table vector on a falling edge, lets one rising edge pass and compares on the next falling edge. For the sequencer, `sq_busy` is checked one edge after the start edge. The bench then counts W-1 further edges and confirms the run is still busy with `sq_done` low. It checks the completion pulse, the quotient and the flags after the W-th edge, and confirms that `sq_done` has dropped one edge later. The tests for an ignored start and for reset in mid-run follow the same fixed edge counts, so every check samples exactly where the result is due.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

   // Flag triple carried between division steps
   typedef struct packed {
      logic q;
      logic m;
      logic t;
   } ndiv_flags_t;

endpackage

// File: rtl/ndiv_step_core.sv
module ndiv_step_core
   import ndiv_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [W-1:0] divisor,
   input  logic [W-1:0] rem_in,
   input  ndiv_flags_t  fin,
   output logic [W-1:0] rem_out,
   output logic         q_out,
   output logic         t_out
);

   if (W < 2) begin : g_chk_w
      $error("ndiv_step_core: W must be at least 2");
   end

   logic         q_mid;    // sign of remainder before the shift
   logic [W-1:0] shifted;
   logic         do_sub;
   logic         cb;       // carry of add or borrow of subtract

   assign q_mid   = rem_in[W-1];
   assign shifted = {rem_in[W-2:0], fin.t};
   assign do_sub  = (fin.q == fin.m);

   if (SHARED_ADDER) begin : g_shared
      // one adder: subtract as add of inverted operand plus one
      logic [W:0]   sum;
      logic [W-1:0] opnd;
      assign opnd    = do_sub ? ~divisor : divisor;
      assign sum     = {1'b0, shifted} + {1'b0, opnd} + {{W{1'b0}}, do_sub};
      assign rem_out = sum[W-1:0];
      assign cb      = do_sub ? ~sum[W] : sum[W];
   end else begin : g_dual
      // two adders in parallel, result picked afterwards
      logic [W:0] dif;
      logic [W:0] add;
      assign dif     = {1'b0, shifted} - {1'b0, divisor};
      assign add     = {1'b0, shifted} + {1'b0, divisor};
      assign rem_out = do_sub ? dif[W-1:0] : add[W-1:0];
      assign cb      = do_sub ? dif[W] : add[W];
   end

   assign q_out = q_mid ^ cb ^ fin.m;
   assign t_out = ~(q_out ^ fin.m);

endmodule

// File: rtl/ndiv_step_reg.sv
module ndiv_step_reg
   import ndiv_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] divisor,
   input  logic [W-1:0] rem_in,
   input  ndiv_flags_t  fin,
   output logic [W-1:0] rem_o,
   output logic         q_o,
   output logic         t_o,
   output logic         vld
);

   logic [W-1:0] rem_nx;
   logic         q_nx;
   logic         t_nx;

   ndiv_step_core #(.W(W), .SHARED_ADDER(SHARED_ADDER)) core_i (
      .divisor (divisor),
      .rem_in  (rem_in),
      .fin     (fin),
      .rem_out (rem_nx),
      .q_out   (q_nx),
      .t_out   (t_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_o <= '0;
         q_o   <= 1'b0;
         t_o   <= 1'b0;
         vld   <= 1'b0;
      end else begin
         vld <= en;
         if (en) begin
            rem_o <= rem_nx;
            q_o   <= q_nx;
            t_o   <= t_nx;
         end
      end
   end

   // R5: outputs hold without a strobe
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable({rem_o, q_o, t_o}));
   // R5: valid follows the strobe by one edge
   a_r5_vld_set: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> vld);
   a_r5_vld_clr: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !vld);
   // R4: registered T agrees with registered Q and the sampled M
   a_r4_t_agrees_m: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (t_o == (q_o == $past(fin.m))));

endmodule

// File: rtl/ndiv_seq.sv
module ndiv_seq
   import ndiv_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] divisor,
   input  logic [W-1:0] rem_in,
   input  logic [W-1:0] quo_in,
   input  logic         q_in,
   input  logic         m_in,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] rem_o,
   output logic [W-1:0] quo_o,
   output logic         q_o,
   output logic         m_o,
   output logic         t_o
);

   localparam int              CW   = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0]   LAST = CW'(W - 1);

   logic [W-1:0]  div_r;
   logic [W-1:0]  rem_r;
   logic [W-1:0]  quo_r;
   logic          q_r;
   logic          m_r;
   logic          t_r;
   logic [CW-1:0] cnt;

   ndiv_flags_t   fcur;
   logic [W-1:0]  rem_nx;
   logic          q_nx;
   logic          t_nx;

   // incoming T of each step is the bit rotated out of the quotient
   assign fcur = '{q: q_r, m: m_r, t: quo_r[W-1]};

   ndiv_step_core #(.W(W), .SHARED_ADDER(SHARED_ADDER)) core_i (
      .divisor (div_r),
      .rem_in  (rem_r),
      .fin     (fcur),
      .rem_out (rem_nx),
      .q_out   (q_nx),
      .t_out   (t_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_r <= '0;
         rem_r <= '0;
         quo_r <= '0;
         q_r   <= 1'b0;
         m_r   <= 1'b0;
         t_r   <= 1'b0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               div_r <= divisor;
               rem_r <= rem_in;
               quo_r <= quo_in;
               q_r   <= q_in;
               m_r   <= m_in;
               t_r   <= 1'b0;
               cnt   <= '0;
               busy  <= 1'b1;
            end
         end else begin
            rem_r <= rem_nx;
            q_r   <= q_nx;
            t_r   <= t_nx;
            quo_r <= {quo_r[W-2:0], t_nx};
            if (cnt == LAST) begin
               cnt  <= '0;
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign rem_o = rem_r;
   assign quo_o = quo_r;
   assign q_o   = q_r;
   assign m_o   = m_r;
   assign t_o   = t_r;

   // R6: M untouched while stepping
   a_r6_m_stable: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(m_r));
   // R7: run continues until the last step
   a_r7_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != LAST) |=> busy);
   // R8: done is a single-cycle pulse issued while idle
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: start while busy only lets the count advance
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && cnt != LAST) |=> (busy && cnt == $past(cnt) + 1'b1));
   // R10: idle sequencer holds a cleared counter
   a_r10_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cnt == '0));
   // R4: T after each step agrees with Q and M
   a_r4_seq_t: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (t_r == (q_r == m_r)));

endmodule

// File: rtl/ndiv_unit.sv
module ndiv_unit
   import ndiv_pkg::*;
#(
   parameter int W            = 32,
   parameter bit SEQ_EN       = 1'b1,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stp_en,
   input  logic [W-1:0] stp_divisor,
   input  logic [W-1:0] stp_rem,
   input  logic         stp_q,
   input  logic         stp_m,
   input  logic         stp_t,
   output logic [W-1:0] stp_rem_o,
   output logic         stp_q_o,
   output logic         stp_t_o,
   output logic         stp_vld,
   input  logic         sq_start,
   input  logic [W-1:0] sq_divisor,
   input  logic [W-1:0] sq_rem,
   input  logic [W-1:0] sq_quo,
   input  logic         sq_q,
   input  logic         sq_m,
   output logic         sq_busy,
   output logic         sq_done,
   output logic [W-1:0] sq_rem_o,
   output logic [W-1:0] sq_quo_o,
   output logic         sq_q_o,
   output logic         sq_m_o,
   output logic         sq_t_o
);

   ndiv_flags_t stp_flags;
   assign stp_flags = '{q: stp_q, m: stp_m, t: stp_t};

   ndiv_step_reg #(.W(W), .SHARED_ADDER(SHARED_ADDER)) step_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (stp_en),
      .divisor (stp_divisor),
      .rem_in  (stp_rem),
      .fin     (stp_flags),
      .rem_o   (stp_rem_o),
      .q_o     (stp_q_o),
      .t_o     (stp_t_o),
      .vld     (stp_vld)
   );

   if (SEQ_EN) begin : g_seq
      ndiv_seq #(.W(W), .SHARED_ADDER(SHARED_ADDER)) seq_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (sq_start),
         .divisor (sq_divisor),
         .rem_in  (sq_rem),
         .quo_in  (sq_quo),
         .q_in    (sq_q),
         .m_in    (sq_m),
         .busy    (sq_busy),
         .done    (sq_done),
         .rem_o   (sq_rem_o),
         .quo_o   (sq_quo_o),
         .q_o     (sq_q_o),
         .m_o     (sq_m_o),
         .t_o     (sq_t_o)
      );
   end else begin : g_noseq
      assign sq_busy  = 1'b0;
      assign sq_done  = 1'b0;
      assign sq_rem_o = '0;
      assign sq_quo_o = '0;
      assign sq_q_o   = 1'b0;
      assign sq_m_o   = 1'b0;
      assign sq_t_o   = 1'b0;
   end

endmodule

// File: tb/ndiv_unit_tb.sv
module ndiv_unit_tb_top;

   localparam int W  = 32;
   localparam int NV = 9;

   // single-step vectors: divisor, remainder, {q,m,t} in, remainder, {q,t} out
   localparam logic [31:0] V_DIV [NV] = '{32'h1, 32'h3, 32'h5, 32'h5,
      32'h8000_0000, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'h7, 32'h0};
   localparam logic [31:0] V_REM [NV] = '{32'h5, 32'h1, 32'h1, 32'hFFFF_FFFD,
      32'h4000_0000, 32'h3, 32'h8000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
   localparam logic [2:0]  V_QMT [NV] = '{3'b000, 3'b001, 3'b000, 3'b101,
      3'b000, 3'b110, 3'b011, 3'b010, 3'b001};
   localparam logic [31:0] E_REM [NV] = '{32'h9, 32'h0, 32'hFFFF_FFFD, 32'h0,
      32'h0, 32'h8, 32'h1, 32'h5, 32'hFFFF_FFFF};
   localparam logic [1:0]  E_QT  [NV] = '{2'b01, 2'b01, 2'b10, 2'b01,
      2'b01, 2'b00, 2'b11, 2'b11, 2'b10};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         stp_en = 1'b0;
   logic [W-1:0] stp_divisor = '0;
   logic [W-1:0] stp_rem = '0;
   logic         stp_q = 1'b0, stp_m = 1'b0, stp_t = 1'b0;
   logic [W-1:0] stp_rem_o;
   logic         stp_q_o, stp_t_o, stp_vld;
   logic         sq_start = 1'b0;
   logic [W-1:0] sq_divisor = '0, sq_rem = '0, sq_quo = '0;
   logic         sq_q = 1'b0, sq_m = 1'b0;
   logic         sq_busy, sq_done, sq_q_o, sq_m_o, sq_t_o;
   logic [W-1:0] sq_rem_o, sq_quo_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   ndiv_unit #(.W(W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .stp_en(stp_en), .stp_divisor(stp_divisor), .stp_rem(stp_rem),
      .stp_q(stp_q), .stp_m(stp_m), .stp_t(stp_t),
      .stp_rem_o(stp_rem_o), .stp_q_o(stp_q_o), .stp_t_o(stp_t_o), .stp_vld(stp_vld),
      .sq_start(sq_start), .sq_divisor(sq_divisor), .sq_rem(sq_rem), .sq_quo(sq_quo),
      .sq_q(sq_q), .sq_m(sq_m),
      .sq_busy(sq_busy), .sq_done(sq_done), .sq_rem_o(sq_rem_o), .sq_quo_o(sq_quo_o),
      .sq_q_o(sq_q_o), .sq_m_o(sq_m_o), .sq_t_o(sq_t_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // full division through the sequencer; inject issues a start mid-run
   task automatic run_div(input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] d, input logic m, input bit inject);
      logic [63:0] dividend;
      logic [63:0] quot;
      dividend = {hi, lo};
      quot = dividend / {32'h0, d};
      @(negedge clk);
      sq_start = 1'b1; sq_divisor = d; sq_rem = hi; sq_quo = lo;
      sq_q = 1'b0; sq_m = m;
      @(posedge clk);
      @(negedge clk);
      sq_start = 1'b0;
      chk("R7 busy after start", {63'h0, sq_busy}, 64'h1);
      for (int i = 1; i < W; i++) begin
         if (inject && i == 5) begin
            sq_start = 1'b1; sq_divisor = 32'h3; sq_rem = 32'h1;
            sq_quo = 32'hAAAA_5555; sq_m = ~m;
         end
         @(posedge clk);
         @(negedge clk);
         sq_start = 1'b0;
      end
      chk("R7 still busy before last step", {62'h0, sq_busy, sq_done}, 64'h2);
      @(posedge clk);
      @(negedge clk);
      chk("R8 done with busy low at step W", {62'h0, sq_busy, sq_done}, 64'h1);
      chk("R6 M held", {63'h0, sq_m_o}, {63'h0, m});
      if (!m) begin
         chk(inject ? "R9 quotient unaffected by mid-run start" : "R11 quotient",
             {32'h0, sq_quo_o}, {32'h0, quot[31:0]});
         chk("R4 final T equals last quotient bit", {63'h0, sq_t_o},
             {63'h0, quot[0]});
      end
      @(posedge clk);
      @(negedge clk);
      chk("R8 done lasts one cycle", {63'h0, sq_done}, 64'h0);
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R10 reset step outputs", {30'h0, stp_rem_o, stp_q_o, stp_t_o, stp_vld}, 64'h0);
      chk("R10 reset sequencer idle", {62'h0, sq_busy, sq_done}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4: vector table through the single-step port
      for (int k = 0; k < NV; k++) begin
         stp_en = 1'b1;
         stp_divisor = V_DIV[k]; stp_rem = V_REM[k];
         {stp_q, stp_m, stp_t} = V_QMT[k];
         @(posedge clk);
         @(negedge clk);
         stp_en = 1'b0;
         chk($sformatf("R1/R2 remainder vector %0d", k), {32'h0, stp_rem_o}, {32'h0, E_REM[k]});
         chk($sformatf("R3/R4 flags vector %0d", k), {62'h0, stp_q_o, stp_t_o},
             {62'h0, E_QT[k]});
         chk("R5 valid after strobe", {63'h0, stp_vld}, 64'h1);
      end

      // R5: outputs hold with the strobe low
      stp_divisor = 32'h1234; stp_rem = 32'h5678; {stp_q, stp_m, stp_t} = 3'b111;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 hold remainder", {32'h0, stp_rem_o}, {32'h0, E_REM[NV-1]});
      chk("R5 hold flags", {61'h0, stp_q_o, stp_t_o, stp_vld}, {61'h0, E_QT[NV-1], 1'b0});

      // R11: unsigned divisions
      run_div(32'h0, 32'd100, 32'd7, 1'b0, 1'b0);
      run_div(32'h0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
      run_div(32'h5, 32'h1234_5678, 32'h10, 1'b0, 1'b0);
      run_div(32'h1, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0);
      run_div(32'h0BAD_F00D, 32'hCAFE_1234, 32'h1234_5679, 1'b0, 1'b0);
      // R6: run with M set keeps M
      run_div(32'h3, 32'h9, 32'hFFFF_FFF0, 1'b1, 1'b0);
      // R9: start while busy is ignored
      run_div(32'h0, 32'd1000, 32'd9, 1'b0, 1'b1);

      // R10: reset mid-run aborts, then a full run still takes W steps
      @(negedge clk);
      sq_start = 1'b1; sq_divisor = 32'd3; sq_rem = 32'h0; sq_quo = 32'd50;
      @(posedge clk);
      @(negedge clk);
      sq_start = 1'b0;
      repeat (10) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R10 reset aborts run", {62'h0, sq_busy, sq_done}, 64'h0);
      chk("R10 reset clears step valid", {63'h0, stp_vld}, 64'h0);
      rst_n = 1'b1;
      run_div(32'h0, 32'd50, 32'd3, 1'b0, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule